// File: doc/BRIEF.md
# Serial Wire Debug link bring-up sequencer

This controller takes a Serial Wire Debug target whose line state is unknown and leaves it with a memory-bus access port ready for word transfers. It drives two downstream engines and does no wire timing itself. A raw shift engine receives word-sized bit commands. A transaction engine receives debug-port (DP) and access-port (AP) register reads and writes. The controller first resets the line and sends the selection pattern that moves the target from JTAG to SWD. It then reads and checks the identity register, requests power-up and waits for it, resets the debug domain, checks that access port 0 is a memory-bus port, and writes its control word.

A one-cycle `start` pulse begins the sequence. `busy` stays high until the controller reaches either `done` or `err`. That result is held until the next `start`. Every failing step has its own error code, so software or a supervising block can tell where bring-up stopped. A `start` given while a run is in progress drops the current step and starts again from the line reset.

Top module: `swdb_bringup`

## Requirements
- R1: While reset is high and after it, with no start seen, `busy`, `done`, `err`, `shf_req` and `txn_req` are low and `err_code` is 0.
- R2: The run first issues eight shift commands, in this order. (1) One turnaround: `shf_turn`=1, `shf_len`=1, bits 0. (2) and (3) 32 one-bits each. (4) 16 bits of value 0xE79E. (5) and (6) 32 one-bits each. (7) and (8) 32 zero-bits each. `shf_len` is the bit count and `shf_bits` is sent LSB first.
- R3: Next comes a DP read of address 0x00 (`txn_ap`=0, `txn_rnw`=1). An engine error ends the run with code 1. If the read value ANDed with 0x0FF00001 is not 0x0BA00001, the run ends with code 2.
- R4: Next comes a DP write of 0x50000000 to address 0x04, which sets the request bits 30 and 28. Then DP reads of 0x04 follow until bits 31 and 29 are both set, with at most POLL_MAX reads (default 4). An engine error at any point in this step, or no acknowledge within the read limit, ends the run with code 3.
- R5: Next comes a DP write of 0x54000000 to 0x04, which adds request bit 26. Then up to POLL_MAX reads of 0x04 wait for bits 31, 29 and 27. After that a DP write of 0x50000000 to 0x04 clears bit 26. An engine error anywhere in this step, or no acknowledge within the limit, gives code 4.
- R6: Next comes an AP read of register 0xFC (`txn_ap`=1). An engine error, or a low nibble other than 1, gives code 5.
- R7: Finally comes an AP write of 0x00000052 to register 0x00. An engine error gives code 6. Success raises `done` with code 0.
- R8: An engine error, or a failed check, ends the run at once. No request follows it. `done` and `err` are never high together.
- R9: `start` restarts from the first shift command of R2. `busy` is high from the cycle after `start` until the cycle in which `done` or `err` rises. `done`, `err` and `err_code` hold until the next start.
- R10: A request stays high with a stable payload until its acknowledge (`shf_ack` or `txn_done`). A request that is still high in the cycle after an acknowledge is a new command. The shift and transaction requests are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts bring-up |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Bring-up finished successfully (held) |
| err | output | 1 | Bring-up failed (held) |
| err_code | output | 3 | Failing step: 1 no target, 2 bad part, 3 power, 4 reset, 5 AP identity, 6 CSW |
| shf_req | output | 1 | Shift command valid |
| shf_turn | output | 1 | Command is a single turnaround cycle |
| shf_len | output | 6 | Number of bits to shift (1..32) |
| shf_bits | output | 32 | Bits to shift, LSB first |
| shf_ack | input | 1 | One-cycle completion of the shift command |
| txn_req | output | 1 | Register transaction valid |
| txn_ap | output | 1 | 1 = access port, 0 = debug port |
| txn_rnw | output | 1 | 1 = read, 0 = write |
| txn_addr | output | 8 | Register address (AP bank handled by engine) |
| txn_wdata | output | 32 | Write data |
| txn_done | input | 1 | One-cycle completion of the transaction |
| txn_err | input | 1 | Transaction failed; valid with `txn_done` |
| txn_rdata | input | 32 | Read data; valid with `txn_done` |

## Verification
The properties assume three things about the inputs. `shf_ack` and `txn_done` are single-cycle pulses that come only while the matching request is high. `txn_err` and `txn_rdata` only matter in a completion cycle. `start` is a pulse. The bench models both engines under these rules and clears their pending state whenever reset or `start` is high, so no acknowledge from an abandoned command reaches a new run. Engine latency changes between runs. The modelled target gives back the identity, status, acknowledge and port-identity values that each scenario calls for.

// File: rtl/swdb_pkg.sv
package swdb_pkg;

    localparam int WORD_W     = 32;
    localparam int LEN_W      = 6;
    localparam int REG_AW     = 8;
    localparam int CODE_W     = 3;
    localparam int LINE_STEPS = 8;

    // Control/status word bit positions on the debug port
    localparam int SYS_ACK = 31;
    localparam int SYS_REQ = 30;
    localparam int DBG_ACK = 29;
    localparam int DBG_REQ = 28;
    localparam int RST_ACK = 27;
    localparam int RST_REQ = 26;

    localparam logic [REG_AW-1:0] DP_ID_REG   = 8'h00;
    localparam logic [REG_AW-1:0] DP_CTRL_REG = 8'h04;
    localparam logic [REG_AW-1:0] AP_IDR_REG  = 8'hFC;
    localparam logic [REG_AW-1:0] AP_CSW_REG  = 8'h00;

    typedef enum logic [CODE_W-1:0] {
        FAIL_NONE      = 3'd0,
        FAIL_NO_TARGET = 3'd1,
        FAIL_BAD_PART  = 3'd2,
        FAIL_POWER     = 3'd3,
        FAIL_RESET     = 3'd4,
        FAIL_AP_ID     = 3'd5,
        FAIL_CSW       = 3'd6
    } fail_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LINE, ST_ID, ST_PWR_SET, ST_PWR_POLL, ST_RST_SET,
        ST_RST_POLL, ST_RST_CLR, ST_AP_ID, ST_CSW, ST_DONE, ST_FAIL
    } step_e;

    typedef struct packed {
        logic              turn;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] bits;
    } shift_cmd_t;

    typedef struct packed {
        logic              ap;
        logic              rnw;
        logic [REG_AW-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } txn_cmd_t;

    function automatic shift_cmd_t line_cmd(input logic [2:0] idx);
        shift_cmd_t c;
        c = '{turn: 1'b0, len: LEN_W'(32), bits: '1};
        case (idx)
            3'd0:       c = '{turn: 1'b1, len: LEN_W'(1), bits: '0};
            3'd3:       c = '{turn: 1'b0, len: LEN_W'(16), bits: WORD_W'(16'hE79E)};
            3'd6, 3'd7: c.bits = '0;
            default:    ;
        endcase
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input logic with_rst);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SYS_REQ] = 1'b1;
        w[DBG_REQ] = 1'b1;
        w[RST_REQ] = with_rst;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] csw_word();
        logic [WORD_W-1:0] w;
        w = '0;
        w[6]   = 1'b1;    // port enable
        w[5:4] = 2'b01;   // advance address by one word
        w[2:0] = 3'b010;  // word-sized access
        return w;
    endfunction

    function automatic logic part_ok(input logic [WORD_W-1:0] id);
        return (id & 32'h0FF0_0001) == 32'h0BA0_0001;
    endfunction

    function automatic logic pwr_acked(input logic [WORD_W-1:0] w);
        return w[SYS_ACK] && w[DBG_ACK];
    endfunction

    function automatic logic rst_acked(input logic [WORD_W-1:0] w);
        return w[SYS_ACK] && w[DBG_ACK] && w[RST_ACK];
    endfunction

    function automatic logic mem_ap_ok(input logic [WORD_W-1:0] idr);
        return idr[3:0] == 4'd1;
    endfunction

    function automatic fail_e step_fail(input step_e s);
        case (s)
            ST_ID:                             return FAIL_NO_TARGET;
            ST_PWR_SET, ST_PWR_POLL:           return FAIL_POWER;
            ST_RST_SET, ST_RST_POLL, ST_RST_CLR: return FAIL_RESET;
            ST_AP_ID:                          return FAIL_AP_ID;
            default:                           return FAIL_CSW;
        endcase
    endfunction

endpackage

// File: rtl/swdb_line_init.sv
module swdb_line_init
    import swdb_pkg::*;
#(
    parameter int STEPS = LINE_STEPS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       shf_ack,
    output logic       shf_req,
    output shift_cmd_t cmd,
    output logic       fin
);
    localparam int IW = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic          run_q;
    logic [IW-1:0] idx_q;
    logic          last;

    assign last    = (idx_q == IW'(STEPS - 1));
    assign shf_req = run_q;
    assign fin     = run_q && shf_ack && last;
    assign cmd     = line_cmd(3'(idx_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            idx_q <= '0;
        end else if (go) begin
            run_q <= 1'b1;
            idx_q <= '0;
        end else if (run_q && shf_ack) begin
            if (last) begin
                run_q <= 1'b0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swdb_txn_decode.sv
module swdb_txn_decode
    import swdb_pkg::*;
(
    input  step_e    step,
    output logic     active,
    output txn_cmd_t cmd
);
    always_comb begin
        active = 1'b1;
        cmd    = '{ap: 1'b0, rnw: 1'b1, addr: DP_CTRL_REG, wdata: '0};
        case (step)
            ST_ID:       cmd.addr = DP_ID_REG;
            ST_PWR_SET:  begin cmd.rnw = 1'b0; cmd.wdata = ctrl_word(1'b0); end
            ST_PWR_POLL: ;
            ST_RST_SET:  begin cmd.rnw = 1'b0; cmd.wdata = ctrl_word(1'b1); end
            ST_RST_POLL: ;
            ST_RST_CLR:  begin cmd.rnw = 1'b0; cmd.wdata = ctrl_word(1'b0); end
            ST_AP_ID:    begin cmd.ap = 1'b1; cmd.addr = AP_IDR_REG; end
            ST_CSW:      begin
                cmd.ap    = 1'b1;
                cmd.rnw   = 1'b0;
                cmd.addr  = AP_CSW_REG;
                cmd.wdata = csw_word();
            end
            default:     active = 1'b0;
        endcase
    end
endmodule

// File: rtl/swdb_bringup.sv
module swdb_bringup
    import swdb_pkg::*;
#(
    parameter int POLL_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CODE_W-1:0] err_code,
    output logic              shf_req,
    output logic              shf_turn,
    output logic [LEN_W-1:0]  shf_len,
    output logic [WORD_W-1:0] shf_bits,
    input  logic              shf_ack,
    output logic              txn_req,
    output logic              txn_ap,
    output logic              txn_rnw,
    output logic [REG_AW-1:0] txn_addr,
    output logic [WORD_W-1:0] txn_wdata,
    input  logic              txn_done,
    input  logic              txn_err,
    input  logic [WORD_W-1:0] txn_rdata
);
    localparam int PW = $clog2(POLL_MAX) + 1;

    step_e         step_q;
    fail_e         code_q;
    logic [PW-1:0] polls_q;
    logic          poll_last;
    logic          line_fin;
    logic          line_req;
    shift_cmd_t    line_c;
    logic          txn_active;
    txn_cmd_t      txn_c;

    swdb_line_init #(.STEPS(LINE_STEPS)) u_line (
        .clk     (clk),
        .rst     (rst),
        .go      (start),
        .shf_ack (shf_ack),
        .shf_req (line_req),
        .cmd     (line_c),
        .fin     (line_fin)
    );

    swdb_txn_decode u_dec (
        .step   (step_q),
        .active (txn_active),
        .cmd    (txn_c)
    );

    assign poll_last = (polls_q == PW'(POLL_MAX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            code_q  <= FAIL_NONE;
            polls_q <= '0;
        end else if (start) begin
            step_q  <= ST_LINE;
            code_q  <= FAIL_NONE;
            polls_q <= '0;
        end else if (step_q == ST_LINE) begin
            if (line_fin) step_q <= ST_ID;
        end else if (txn_active && txn_done) begin
            if (txn_err) begin
                step_q <= ST_FAIL;
                code_q <= step_fail(step_q);
            end else begin
                case (step_q)
                    ST_ID: begin
                        if (part_ok(txn_rdata)) step_q <= ST_PWR_SET;
                        else begin step_q <= ST_FAIL; code_q <= FAIL_BAD_PART; end
                    end
                    ST_PWR_SET: begin
                        polls_q <= '0;
                        step_q  <= ST_PWR_POLL;
                    end
                    ST_PWR_POLL: begin
                        if (pwr_acked(txn_rdata)) step_q <= ST_RST_SET;
                        else if (poll_last) begin step_q <= ST_FAIL; code_q <= FAIL_POWER; end
                        else polls_q <= polls_q + 1'b1;
                    end
                    ST_RST_SET: begin
                        polls_q <= '0;
                        step_q  <= ST_RST_POLL;
                    end
                    ST_RST_POLL: begin
                        if (rst_acked(txn_rdata)) step_q <= ST_RST_CLR;
                        else if (poll_last) begin step_q <= ST_FAIL; code_q <= FAIL_RESET; end
                        else polls_q <= polls_q + 1'b1;
                    end
                    ST_RST_CLR: step_q <= ST_AP_ID;
                    ST_AP_ID: begin
                        if (mem_ap_ok(txn_rdata)) step_q <= ST_CSW;
                        else begin step_q <= ST_FAIL; code_q <= FAIL_AP_ID; end
                    end
                    default: step_q <= ST_DONE;
                endcase
            end
        end
    end

    assign shf_req   = line_req && (step_q == ST_LINE);
    assign shf_turn  = line_c.turn;
    assign shf_len   = line_c.len;
    assign shf_bits  = line_c.bits;

    assign txn_req   = txn_active;
    assign txn_ap    = txn_c.ap;
    assign txn_rnw   = txn_c.rnw;
    assign txn_addr  = txn_c.addr;
    assign txn_wdata = txn_c.wdata;

    assign done      = (step_q == ST_DONE);
    assign err       = (step_q == ST_FAIL);
    assign busy      = !(step_q == ST_IDLE || done || err);
    assign err_code  = code_q;
endmodule

// File: rtl/swdb_bringup_chk.sv
module swdb_bringup_chk
    import swdb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [CODE_W-1:0] err_code,
    input logic              shf_req,
    input logic              shf_turn,
    input logic [LEN_W-1:0]  shf_len,
    input logic [WORD_W-1:0] shf_bits,
    input logic              shf_ack,
    input logic              txn_req,
    input logic              txn_ap,
    input logic              txn_rnw,
    input logic [REG_AW-1:0] txn_addr,
    input logic [WORD_W-1:0] txn_wdata,
    input logic              txn_done,
    input logic              txn_err
);
    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(shf_req && txn_req));

    // R10
    txn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && !txn_done && !start) |=>
            (txn_req && $stable({txn_ap, txn_rnw, txn_addr, txn_wdata})));

    // R10
    shf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (shf_req && !shf_ack && !start) |=>
            (shf_req && $stable({shf_turn, shf_len, shf_bits})));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done && !err));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8
    engine_err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && txn_done && txn_err && !start) |=> (err && !txn_req && !shf_req));

    // R8
    fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!txn_req && !shf_req && err_code != 3'd0));

    // R7
    done_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code == 3'd0));
endmodule

bind swdb_bringup swdb_bringup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .shf_req   (shf_req),
    .shf_turn  (shf_turn),
    .shf_len   (shf_len),
    .shf_bits  (shf_bits),
    .shf_ack   (shf_ack),
    .txn_req   (txn_req),
    .txn_ap    (txn_ap),
    .txn_rnw   (txn_rnw),
    .txn_addr  (txn_addr),
    .txn_wdata (txn_wdata),
    .txn_done  (txn_done),
    .txn_err   (txn_err)
);

// File: tb/tb_swdb_bringup.sv
module tb_swdb_bringup;
    import swdb_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, start = 1'b0;
    logic        busy, done, err;
    logic [2:0]  err_code;
    logic        shf_req, shf_turn, shf_ack = 1'b0;
    logic [5:0]  shf_len;
    logic [31:0] shf_bits;
    logic        txn_req, txn_ap, txn_rnw, txn_done = 1'b0, txn_err = 1'b0;
    logic [7:0]  txn_addr;
    logic [31:0] txn_wdata, txn_rdata = '0;

    swdb_bringup #(.POLL_MAX(4)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .shf_req(shf_req), .shf_turn(shf_turn), .shf_len(shf_len),
        .shf_bits(shf_bits), .shf_ack(shf_ack), .txn_req(txn_req), .txn_ap(txn_ap),
        .txn_rnw(txn_rnw), .txn_addr(txn_addr), .txn_wdata(txn_wdata),
        .txn_done(txn_done), .txn_err(txn_err), .txn_rdata(txn_rdata));

    int n_cmp = 0, n_bad = 0;

    // scenario knobs
    logic [31:0] sc_id, sc_idr;
    int sc_pwr_after, sc_rst_after, sc_err_on, s_lat, t_lat;
    int exp_code;
    txn_cmd_t   exp_txn[$];
    shift_cmd_t exp_shf[$];

    // engine / target model state
    bit s_pend, t_pend;
    int s_wait, t_wait, txn_count, pwr_reads, rst_reads;
    bit rst_phase;
    txn_cmd_t   t_cur;
    shift_cmd_t s_cur;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic txn_cmd_t mk(input logic ap, input logic rnw,
                                    input logic [7:0] a, input logic [31:0] d);
        txn_cmd_t c;
        c.ap = ap; c.rnw = rnw; c.addr = a; c.wdata = d;
        return c;
    endfunction

    function automatic logic [31:0] respond(input txn_cmd_t c);
        logic [31:0] w;
        w = 32'h0;
        if (!c.ap && c.addr == 8'h04 && !c.rnw && c.wdata[26]) rst_phase = 1'b1;
        if (!c.ap && c.rnw && c.addr == 8'h00) w = sc_id;
        else if (!c.ap && c.rnw && c.addr == 8'h04) begin
            if (rst_phase) begin
                w = 32'hA000_0000;
                if (rst_reads >= sc_rst_after) w[27] = 1'b1;
                rst_reads++;
            end else begin
                if (pwr_reads >= sc_pwr_after) w = 32'hA000_0000;
                pwr_reads++;
            end
        end else if (c.ap && c.rnw && c.addr == 8'hFC) w = sc_idr;
        return w;
    endfunction

    // Expected command streams derived from the requirements
    task automatic plan();
        int k;
        bit hit;
        exp_txn.delete();
        exp_shf.delete();
        // R2 line reset and switch pattern
        exp_shf.push_back('{turn: 1'b1, len: 6'd1, bits: 32'h0});
        exp_shf.push_back('{turn: 1'b0, len: 6'd32, bits: 32'hFFFF_FFFF});
        exp_shf.push_back('{turn: 1'b0, len: 6'd32, bits: 32'hFFFF_FFFF});
        exp_shf.push_back('{turn: 1'b0, len: 6'd16, bits: 32'h0000_E79E});
        exp_shf.push_back('{turn: 1'b0, len: 6'd32, bits: 32'hFFFF_FFFF});
        exp_shf.push_back('{turn: 1'b0, len: 6'd32, bits: 32'hFFFF_FFFF});
        exp_shf.push_back('{turn: 1'b0, len: 6'd32, bits: 32'h0});
        exp_shf.push_back('{turn: 1'b0, len: 6'd32, bits: 32'h0});
        k = 0;
        // R3
        k++; exp_txn.push_back(mk(0, 1, 8'h00, 0));
        if (k == sc_err_on) begin exp_code = 1; return; end
        if ((sc_id & 32'h0FF0_0001) != 32'h0BA0_0001) begin exp_code = 2; return; end
        // R4
        k++; exp_txn.push_back(mk(0, 0, 8'h04, 32'h5000_0000));
        if (k == sc_err_on) begin exp_code = 3; return; end
        hit = 0;
        for (int i = 0; i < 4; i++) begin
            k++; exp_txn.push_back(mk(0, 1, 8'h04, 0));
            if (k == sc_err_on) begin exp_code = 3; return; end
            if (i >= sc_pwr_after) begin hit = 1; break; end
        end
        if (!hit) begin exp_code = 3; return; end
        // R5
        k++; exp_txn.push_back(mk(0, 0, 8'h04, 32'h5400_0000));
        if (k == sc_err_on) begin exp_code = 4; return; end
        hit = 0;
        for (int i = 0; i < 4; i++) begin
            k++; exp_txn.push_back(mk(0, 1, 8'h04, 0));
            if (k == sc_err_on) begin exp_code = 4; return; end
            if (i >= sc_rst_after) begin hit = 1; break; end
        end
        if (!hit) begin exp_code = 4; return; end
        k++; exp_txn.push_back(mk(0, 0, 8'h04, 32'h5000_0000));
        if (k == sc_err_on) begin exp_code = 4; return; end
        // R6
        k++; exp_txn.push_back(mk(1, 1, 8'hFC, 0));
        if (k == sc_err_on) begin exp_code = 5; return; end
        if (sc_idr[3:0] != 4'd1) begin exp_code = 5; return; end
        // R7
        k++; exp_txn.push_back(mk(1, 0, 8'h00, 32'h0000_0052));
        if (k == sc_err_on) begin exp_code = 6; return; end
        exp_code = 0;
    endtask

    // Engine models, driven at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst || start) begin
                s_pend = 0; t_pend = 0; shf_ack = 1'b0; txn_done = 1'b0; txn_err = 1'b0;
            end else begin
                if (shf_ack) begin shf_ack = 1'b0; s_pend = 0; end
                if (!s_pend && shf_req) begin
                    s_cur = '{turn: shf_turn, len: shf_len, bits: shf_bits};
                    if (exp_shf.size() == 0)
                        chk(0, "R2", "unexpected shift command", shf_bits, 0);
                    else begin
                        chk(s_cur == exp_shf[0], "R2", "shift command bits", shf_bits, exp_shf[0].bits);
                        void'(exp_shf.pop_front());
                    end
                    s_pend = 1; s_wait = s_lat;
                end
                if (s_pend) begin
                    if (s_wait == 0) begin
                        chk(shf_req && {shf_turn, shf_len, shf_bits} == s_cur, "R10",
                            "shift payload held", shf_bits, s_cur.bits);
                        shf_ack = 1'b1;
                    end else s_wait--;
                end

                if (txn_done) begin txn_done = 1'b0; txn_err = 1'b0; t_pend = 0; end
                if (!t_pend && txn_req) begin
                    t_cur = mk(txn_ap, txn_rnw, txn_addr, txn_wdata);
                    txn_count++;
                    if (exp_txn.size() == 0)
                        chk(0, "R8", "unexpected transaction addr", {24'h0, txn_addr}, 0);
                    else begin
                        chk(t_cur == exp_txn[0], "R3-R7 order", "transaction {ap,rnw,addr}",
                            {22'h0, txn_ap, txn_rnw, txn_addr},
                            {22'h0, exp_txn[0].ap, exp_txn[0].rnw, exp_txn[0].addr});
                        chk(txn_wdata == exp_txn[0].wdata, "R5", "transaction wdata",
                            txn_wdata, exp_txn[0].wdata);
                        void'(exp_txn.pop_front());
                    end
                    t_pend = 1; t_wait = t_lat;
                end
                if (t_pend) begin
                    if (t_wait == 0) begin
                        chk(txn_req && mk(txn_ap, txn_rnw, txn_addr, txn_wdata) == t_cur, "R10",
                            "transaction payload held", txn_wdata, t_cur.wdata);
                        txn_done  = 1'b1;
                        txn_err   = (txn_count == sc_err_on);
                        txn_rdata = respond(t_cur);
                    end else t_wait--;
                end
            end
        end
    end

    task automatic kick();
        @(posedge clk); #1;
        txn_count = 0; pwr_reads = 0; rst_reads = 0; rst_phase = 0;
        plan();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run(input string name, input logic [31:0] id, input int pa, input int ra,
                       input logic [31:0] idr, input int eo, input int sl, input int tl);
        int guard;
        sc_id = id; sc_pwr_after = pa; sc_rst_after = ra; sc_idr = idr; sc_err_on = eo;
        s_lat = sl; t_lat = tl;
        kick();
        guard = 0;
        forever begin
            @(negedge clk);
            if (done || err) break;
            // R9 busy throughout the run
            chk(busy == 1'b1, "R9", {name, " busy during run"}, busy, 1);
            guard++;
            if (guard > 4000) begin
                chk(0, "R9", {name, " run never ended"}, 0, 1);
                break;
            end
        end
        chk(busy == 1'b0, "R9", {name, " busy at end"}, busy, 0);
        chk(done == (exp_code == 0), "R7", {name, " done flag"}, done, exp_code == 0);
        chk(err == (exp_code != 0), "R8", {name, " err flag"}, err, exp_code != 0);
        chk(err_code == 3'(exp_code), "R3-R7 code", {name, " err_code"}, err_code, exp_code);
        repeat (6) begin
            @(negedge clk);
            chk(!txn_req && !shf_req, "R8", {name, " quiet after end"}, {txn_req, shf_req}, 0);
            chk(done == (exp_code == 0) && err_code == 3'(exp_code), "R9",
                {name, " result held"}, err_code, exp_code);
        end
        chk(exp_txn.size() == 0 && exp_shf.size() == 0, "R8",
            {name, " all expected commands seen"}, exp_txn.size() + exp_shf.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && !shf_req && !txn_req, "R1", "outputs in reset",
            {busy, done, err, shf_req, txn_req}, 0);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && err_code == 0 && !shf_req && !txn_req, "R1",
            "idle after reset", {busy, done, err, err_code}, 0);

        run("happy",        32'h2BA0_1477, 0, 0,  32'h2477_0011, 0, 0, 0);
        run("late_acks",    32'h0BA0_0001, 3, 3,  32'h0000_0001, 0, 2, 3);
        run("pwr_never",    32'h4BA0_0477, 99, 0, 32'h0000_0001, 0, 1, 1);
        run("rst_never",    32'h2BA0_1477, 1, 99, 32'h0000_0001, 0, 0, 2);
        run("bad_part",     32'h4BA0_0476, 0, 0,  32'h0000_0001, 0, 1, 0);
        run("bad_part_hi",  32'h2CA0_1477, 0, 0,  32'h0000_0001, 0, 0, 0);
        run("no_target",    32'h2BA0_1477, 0, 0,  32'h0000_0001, 1, 0, 1);
        run("pwr_eng_err",  32'h2BA0_1477, 2, 0,  32'h0000_0001, 4, 0, 0);
        run("clr_eng_err",  32'h2BA0_1477, 0, 0,  32'h0000_0001, 6, 0, 0);
        run("ap_not_mem",   32'h2BA0_1477, 0, 0,  32'h0477_0002, 0, 0, 1);
        run("ap_eng_err",   32'h2BA0_1477, 0, 0,  32'h0000_0001, 7, 0, 0);
        run("csw_eng_err",  32'h2BA0_1477, 0, 0,  32'h0000_0001, 8, 1, 1);

        // R9 restart in the middle of a run: the new run begins with the line reset
        sc_id = 32'h2BA0_1477; sc_pwr_after = 99; sc_rst_after = 0; sc_idr = 32'h1;
        sc_err_on = 0; s_lat = 1; t_lat = 1;
        kick();
        repeat (40) @(posedge clk);
        run("restart",      32'h2BA0_1477, 1, 2,  32'h0000_0001, 0, 0, 1);

        // R1 reset in the middle of a run
        sc_err_on = 0; sc_pwr_after = 99;
        kick();
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err && err_code == 0 && !shf_req && !txn_req, "R1",
            "idle after mid-run reset", {busy, done, err, err_code}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule